// File: doc/BRIEF.md
# T1 Zero Code Suppression Encoder

This block sits in the transmit path of a T1 framer, ahead of the bipolar line driver. It takes the outgoing 1.544 Mbit/s bit stream one bit per bit period: each 193-bit frame is one framing bit followed by 24 eight-bit channel octets, most significant bit first. It keeps ones density on the line with one of three schemes chosen at run time (no suppression, bit-7 jamming of all-zero octets, or eight-zero substitution with deliberate bipolar violations). It then turns the result into an alternate mark inversion symbol stream on a positive-pulse / negative-pulse rail pair.

An eight-slot lookahead window holds the bits so that an eight-zero run, or a whole channel octet, can be inspected before its first bit leaves. Every bit therefore appears on the rails exactly eight bit periods after it was accepted, whatever the mode. A single polarity register records the sign of the most recent pulse, so normal marks and substituted pulses share one alternation history. A strobe marks each bit period, and a frame-start flag marks the framing bit so that the octet boundaries are known.

Top module: `zcs_encoder`

## Requirements
- R1: While reset is high the rails are low, and `line_pos` and `line_neg` are never high in the same cycle.
- R2: The symbol for the bit accepted on the n-th strobe after reset appears on the strobe n+8 (counting from 0), in every mode, and no pulse is sent on the first eight strobes after reset.
- R3: The rails change only on a clock edge where `bit_en` is high, and hold their value between strobes.
- R4: A 0 bit produces no pulse and a 1 bit produces a pulse whose polarity is opposite to the previous pulse; the first pulse after reset is positive. Outside the eight-zero substitution mode, consecutive pulses always alternate.
- R5: `zcs_mode` encoding: bit 1 set selects no suppression whatever bit 0 holds; `2'b01` selects eight-zero substitution; `2'b00` selects bit-7 jamming.
- R6: In jamming mode a channel octet equal to 0x00 is sent with its bit 7 set, bit 7 being the seventh bit sent of the octet (bits numbered 1 = MSB, sent first, to 8 = LSB). Octets that are not 0x00 pass unchanged.
- R7: `frame_start` high with a strobe marks that bit as the framing bit. The 192 bits after it are channel bits, eight per octet. The framing bit is never jammed, even when it is 0 next to a zero octet.
- R8: In eight-zero substitution mode, eight consecutive 0 symbols are sent as 0,0,0,V,B,0,V,B. Each V has the polarity of the pulse before it, and each B the opposite polarity. Runs are found left to right, and a substituted slot never takes part in a second substitution.
- R9: A run of seven zeros is sent unchanged in substitution mode, and runs are counted across the framing bit with no regard to frame or octet boundaries.
- R10: After a substitution the next mark takes the polarity opposite to the last B pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per line bit period; accepts `data_bit` and advances the rails |
| frame_start | input | 1 | High with the strobe that carries a framing bit |
| data_bit | input | 1 | Transmit bit accepted on the strobe |
| zcs_mode | input | 2 | Suppression select: 1x none, 01 eight-zero substitution, 00 bit-7 jamming |
| line_pos | output | 1 | Positive pulse rail |
| line_neg | output | 1 | Negative pulse rail |

## Verification
Channel data mixing zero octets, sparse octets and dense octets is sent in transparent mode under both encodings of that mode. This shows that no ones are added and that bit 0 of the mode is ignored. The same kind of mix in jamming mode, with a zero framing bit next to a zero first octet, tells a jammed bit 7 apart from a jammed framing bit or a wrong bit position. In substitution mode, back-to-back zero octets, seven-zero gaps between marks and a zero run crossing the framing bit tell the substitution pattern, its V and B polarities, the polarity of the next mark and the run boundaries apart. A bench model compares every rail value bit by bit. Runs of all ones in each mode pin down the fixed eight-bit delay.

// File: rtl/zcs_pkg.sv
`timescale 1ns/1ps
package zcs_pkg;

    // Length of the substitution pattern; also the lookahead depth.
    localparam int B8ZS_LEN = 8;
    localparam int WIN      = B8ZS_LEN;
    localparam int JAM_SLOT = WIN - 2;   // bit 7 of the octet whose LSB sits in the last slot

    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,
        SYM_MARK  = 2'd1,
        SYM_VIOL  = 2'd2
    } sym_t;

    typedef struct packed {
        logic valid;
        sym_t sym;
    } slot_t;

    typedef enum logic [1:0] {
        ZCS_NONE = 2'd0,
        ZCS_JAM  = 2'd1,
        ZCS_B8ZS = 2'd2
    } zcs_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } pulse_t;

    // Bit 1 forces transparent operation; otherwise bit 0 picks substitution.
    function automatic zcs_t decode_mode(input logic [1:0] m);
        if (m[1])      return ZCS_NONE;
        else if (m[0]) return ZCS_B8ZS;
        else           return ZCS_JAM;
    endfunction

    // Slot contents of the eight-zero replacement: 0 0 0 V B 0 V B
    function automatic sym_t b8zs_sym(input int idx);
        case (idx)
            3, 6:    return SYM_VIOL;
            4, 7:    return SYM_MARK;
            default: return SYM_SPACE;
        endcase
    endfunction

endpackage

// File: rtl/zcs_frame_pos.sv
`timescale 1ns/1ps
module zcs_frame_pos #(
    parameter int CHANNELS   = 24,
    parameter int OCTET_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic frame_start,
    output logic chan_last
);
    localparam int FRAME_BITS = CHANNELS * OCTET_BITS + 1;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur_pos;

    // Position 0 is the framing bit; channel bits occupy 1 .. FRAME_BITS-1.
    always_comb begin
        if (frame_start)
            cur_pos = '0;
        else if (pos_q == LAST_POS)
            cur_pos = '0;
        else
            cur_pos = pos_q + 1'b1;
    end

    // The LSB of a channel octet lands on a multiple of the octet width.
    assign chan_last = (cur_pos != '0) && ((int'(cur_pos) % OCTET_BITS) == 0);

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= LAST_POS;
        else if (bit_en)
            pos_q <= cur_pos;
    end
endmodule

// File: rtl/zcs_window.sv
`timescale 1ns/1ps
module zcs_window
    import zcs_pkg::*;
#(
    parameter int OCTET_BITS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  logic  data_bit,
    input  logic  chan_last,
    input  zcs_t  mode,
    output slot_t head
);
    slot_t            win_q   [WIN];
    slot_t            shifted [WIN];
    slot_t            win_d   [WIN];
    slot_t            new_slot;
    logic [WIN-1:0]   zero_vec;
    logic             octet_zero;

    assign new_slot = '{valid: 1'b1, sym: (data_bit ? SYM_MARK : SYM_SPACE)};

    for (genvar i = 0; i < WIN; i++) begin : g_slot
        if (i == WIN - 1) begin : g_tail
            assign shifted[i] = new_slot;
        end else begin : g_body
            assign shifted[i] = win_q[i+1];
        end
        assign zero_vec[i] = shifted[i].valid && (shifted[i].sym == SYM_SPACE);
    end

    // Whole octet present: its LSB just entered the last slot.
    assign octet_zero = &zero_vec[WIN-1 -: OCTET_BITS];

    always_comb begin
        win_d = shifted;
        if (mode == ZCS_JAM && chan_last && octet_zero)
            win_d[JAM_SLOT].sym = SYM_MARK;
        if (mode == ZCS_B8ZS && (&zero_vec)) begin
            for (int i = 0; i < WIN; i++)
                win_d[i] = '{valid: 1'b1, sym: b8zs_sym(i)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WIN; i++)
                win_q[i] <= '{valid: 1'b0, sym: SYM_SPACE};
        end else if (bit_en) begin
            for (int i = 0; i < WIN; i++)
                win_q[i] <= win_d[i];
        end
    end

    assign head = win_q[0];
endmodule

// File: rtl/zcs_ami.sv
`timescale 1ns/1ps
module zcs_ami
    import zcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  slot_t head,
    output logic  line_pos,
    output logic  line_neg
);
    logic   last_pos_q;   // sign of the most recent pulse (1 = positive)
    pulse_t nxt;
    logic   flip;

    always_comb begin
        nxt  = '{pos: 1'b0, neg: 1'b0};
        flip = 1'b0;
        if (head.valid) begin
            unique case (head.sym)
                SYM_MARK: begin
                    nxt  = '{pos: !last_pos_q, neg: last_pos_q};
                    flip = 1'b1;
                end
                SYM_VIOL: nxt = '{pos: last_pos_q, neg: !last_pos_q};
                default:  nxt = '{pos: 1'b0, neg: 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos_q <= 1'b0;
            line_pos   <= 1'b0;
            line_neg   <= 1'b0;
        end else if (bit_en) begin
            line_pos <= nxt.pos;
            line_neg <= nxt.neg;
            if (flip)
                last_pos_q <= !last_pos_q;
        end
    end
endmodule

// File: rtl/zcs_encoder.sv
`timescale 1ns/1ps
module zcs_encoder
    import zcs_pkg::*;
#(
    parameter int CHANNELS   = 24,
    parameter int OCTET_BITS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       frame_start,
    input  logic       data_bit,
    input  logic [1:0] zcs_mode,
    output logic       line_pos,
    output logic       line_neg
);
    zcs_t  mode;
    logic  chan_last;
    slot_t head;

    always_comb mode = decode_mode(zcs_mode);

    zcs_frame_pos #(
        .CHANNELS   (CHANNELS),
        .OCTET_BITS (OCTET_BITS)
    ) i_pos (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .chan_last   (chan_last)
    );

    zcs_window #(
        .OCTET_BITS (OCTET_BITS)
    ) i_win (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .data_bit  (data_bit),
        .chan_last (chan_last),
        .mode      (mode),
        .head      (head)
    );

    zcs_ami i_ami (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .head     (head),
        .line_pos (line_pos),
        .line_neg (line_neg)
    );
endmodule

// File: rtl/zcs_encoder_chk.sv
`timescale 1ns/1ps
module zcs_encoder_chk
    import zcs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic [1:0] zcs_mode,
    input logic       line_pos,
    input logic       line_neg
);
    logic       en_q;
    logic       seen_q;
    logic       last_pos_q;
    logic [4:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            seen_q     <= 1'b0;
            last_pos_q <= 1'b0;
            bits_q     <= '0;
        end else begin
            en_q <= bit_en;
            if (bit_en && bits_q <= 5'(WIN))
                bits_q <= bits_q + 5'd1;
            if (en_q && (line_pos || line_neg)) begin
                seen_q     <= 1'b1;
                last_pos_q <= line_pos;
            end
        end
    end

    AST_ONE_RAIL: assert property (@(posedge clk) disable iff (rst)
        !(line_pos && line_neg));                                                  // R1

    AST_QUIET_FILL: assert property (@(posedge clk) disable iff (rst)
        (bits_q <= 5'(WIN)) |-> !(line_pos || line_neg));                          // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(line_pos) && $stable(line_neg)));                     // R3

    AST_ALT_MARK: assert property (@(posedge clk) disable iff (rst)
        (en_q && (line_pos || line_neg) && seen_q && zcs_mode != 2'b01)
            |-> (line_pos != last_pos_q));                                         // R4
endmodule

bind zcs_encoder zcs_encoder_chk i_zcs_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .zcs_mode (zcs_mode),
    .line_pos (line_pos),
    .line_neg (line_neg)
);

// File: tb/test_zcs_encoder.sv
`timescale 1ns/1ps
module test_zcs_encoder;
    localparam int CLK_HALF = 10;      // 50 MHz
    localparam int FRAME    = 193;
    localparam int MAXN     = 400;
    localparam int DLY      = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       frame_start = 1'b0;
    logic       data_bit = 1'b0;
    logic [1:0] zcs_mode = 2'b11;
    logic       line_pos;
    logic       line_neg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    bit din   [MAXN];
    int sym_m [MAXN];
    bit exp_p [MAXN];
    bit exp_n [MAXN];
    bit got_p [MAXN];
    bit got_n [MAXN];
    bit hold_bad;

    always #CLK_HALF clk = ~clk;

    zcs_encoder i_zcs_encoder (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .data_bit    (data_bit),
        .zcs_mode    (zcs_mode),
        .line_pos    (line_pos),
        .line_neg    (line_neg)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clear_din();
        for (int i = 0; i < MAXN; i++) din[i] = 1'b0;
    endtask

    task automatic set_f(input int f, input bit b);
        din[f*FRAME] = b;
    endtask

    task automatic set_oct(input int f, input int ch, input logic [7:0] v);
        for (int b = 0; b < 8; b++) din[f*FRAME + 1 + ch*8 + b] = v[7-b];
    endtask

    // Independent model: suppression scheme, then polarity, then fixed delay.
    task automatic build_expected(input int n, input logic [1:0] m);
        int kind;
        int i;
        bit allz;
        bit lastp;
        kind = m[1] ? 0 : (m[0] ? 2 : 1);
        for (int k = 0; k < n; k++) sym_m[k] = din[k] ? 1 : 0;
        if (kind == 1) begin
            for (int f = 0; f*FRAME < n; f++) begin
                for (int ch = 0; ch < 24; ch++) begin
                    int base;
                    base = f*FRAME + 1 + ch*8;
                    if (base + 7 < n) begin
                        allz = 1;
                        for (int b = 0; b < 8; b++) if (din[base+b]) allz = 0;
                        if (allz) sym_m[base+6] = 1;
                    end
                end
            end
        end
        if (kind == 2) begin
            i = 0;
            while (i + 7 < n) begin
                allz = 1;
                for (int b = 0; b < 8; b++) if (sym_m[i+b] != 0) allz = 0;
                if (allz) begin
                    sym_m[i+3] = 2; sym_m[i+4] = 1; sym_m[i+6] = 2; sym_m[i+7] = 1;
                    i = i + 8;
                end else begin
                    i = i + 1;
                end
            end
        end
        lastp = 1'b0;
        for (int k = 0; k < n; k++) begin
            exp_p[k] = 1'b0;
            exp_n[k] = 1'b0;
            if (k >= DLY) begin
                if (sym_m[k-DLY] == 1) begin
                    exp_p[k] = !lastp; exp_n[k] = lastp; lastp = !lastp;
                end else if (sym_m[k-DLY] == 2) begin
                    exp_p[k] = lastp; exp_n[k] = !lastp;
                end
            end
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; bit_en = 1'b0; frame_start = 1'b0; zcs_mode = m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input int k);
        data_bit    = din[k];
        frame_start = ((k % FRAME) == 0);
        bit_en      = 1'b1;
        @(negedge clk);
        bit_en      = 1'b0;
        frame_start = 1'b0;
        got_p[k]    = line_pos;
        got_n[k]    = line_neg;
        repeat (3) @(negedge clk);
        if (line_pos !== got_p[k] || line_neg !== got_n[k]) hold_bad = 1'b1;
    endtask

    task automatic run_stream(input logic [1:0] m, input int n, input string req);
        do_reset(m);
        build_expected(n, m);
        hold_bad = 1'b0;
        for (int k = 0; k < n; k++) push(k);
        for (int k = 0; k < n; k++)
            check(got_p[k] == exp_p[k] && got_n[k] == exp_n[k], req,
                  $sformatf("rails at strobe %0d", k),
                  {got_p[k], got_n[k]}, {exp_p[k], exp_n[k]});
        check(!hold_bad, "R3", "rails held between strobes", hold_bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(line_pos == 1'b0 && line_neg == 1'b0, "R1", "rails in reset",
              {line_pos, line_neg}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(line_pos == 1'b0 && line_neg == 1'b0, "R1", "rails after reset",
              {line_pos, line_neg}, 0);
    endtask

    // All-ones data: first pulse on strobe 8 in every mode.
    task automatic t_latency();
        logic [1:0] modes [3];
        int first;
        modes[0] = 2'b00; modes[1] = 2'b01; modes[2] = 2'b11;
        for (int mi = 0; mi < 3; mi++) begin
            clear_din();
            for (int k = 0; k < 40; k++) din[k] = 1'b1;
            run_stream(modes[mi], 40, "R2");
            first = -1;
            for (int k = 39; k >= 0; k--) if (got_p[k] || got_n[k]) first = k;
            check(first == DLY, "R2", $sformatf("first pulse strobe, mode %0d", modes[mi]),
                  first, DLY);
            check(got_p[DLY] == 1'b1, "R4", "first pulse positive", got_p[DLY], 1);
        end
    endtask

    task automatic fill_mixed();
        clear_din();
        set_f(0, 1'b1); set_f(1, 1'b0);
        for (int f = 0; f < 2; f++)
            for (int ch = 0; ch < 24; ch++)
                set_oct(f, ch, (ch % 3 == 0) ? 8'h00 : 8'((ch*37 + f*11) & 8'hFF));
    endtask

    task automatic t_transparent();
        int ones;
        int pulses;
        for (int v = 0; v < 2; v++) begin
            fill_mixed();
            run_stream(v == 0 ? 2'b11 : 2'b10, 386, "R5");
            ones = 0; pulses = 0;
            for (int k = 0; k < 386 - DLY; k++) if (din[k]) ones++;
            for (int k = DLY; k < 386; k++) if (got_p[k] || got_n[k]) pulses++;
            check(pulses == ones, "R4", "no ones added in transparent mode", pulses, ones);
        end
    endtask

    task automatic t_jam();
        clear_din();
        set_f(0, 1'b0); set_f(1, 1'b1);
        for (int f = 0; f < 2; f++)
            for (int ch = 0; ch < 24; ch++)
                set_oct(f, ch, (ch % 2 == 0) ? 8'h00 : 8'((ch*5 + 1) & 8'hFF));
        run_stream(2'b00, 386, "R6");
        check(got_p[DLY] == 1'b0 && got_n[DLY] == 1'b0, "R7", "zero framing bit not jammed",
              {got_p[DLY], got_n[DLY]}, 0);
        check(got_p[DLY+7] == 1'b1, "R6", "bit 7 of zero octet sent as mark",
              got_p[DLY+7], 1);
        check(got_p[DLY+6] == 1'b0 && got_n[DLY+6] == 1'b0 && got_p[DLY+8] == 1'b0
              && got_n[DLY+8] == 1'b0, "R6", "neighbours of jammed bit stay empty",
              {got_p[DLY+6], got_n[DLY+6], got_p[DLY+8], got_n[DLY+8]}, 0);
    endtask

    task automatic t_b8zs();
        bit quiet;
        clear_din();
        set_f(0, 1'b1); set_f(1, 1'b0);
        set_oct(0, 0, 8'h00); set_oct(0, 1, 8'h00);
        set_oct(0, 2, 8'h80); set_oct(0, 3, 8'h80); set_oct(0, 4, 8'h80);
        for (int ch = 5; ch < 23; ch++) set_oct(0, ch, 8'((ch*29 + 3) & 8'hFF));
        set_oct(0, 23, 8'h00);
        set_oct(1, 0, 8'h00);
        for (int ch = 1; ch < 24; ch++) set_oct(1, ch, (ch % 4 == 0) ? 8'h00 : 8'h41);
        run_stream(2'b01, 386, "R8");
        check(got_p[DLY+4] == 1'b1, "R8", "first V repeats preceding positive pulse",
              got_p[DLY+4], 1);
        check(got_n[DLY+5] == 1'b1, "R8", "first B alternates from V", got_n[DLY+5], 1);
        check(got_n[DLY+17] == 1'b1, "R10", "mark after substitution opposes last B",
              got_n[DLY+17], 1);
        quiet = 1'b1;
        for (int k = 18; k <= 24; k++) if (got_p[DLY+k] || got_n[DLY+k]) quiet = 1'b0;
        check(quiet, "R9", "seven-zero run left unsubstituted", !quiet, 0);
        check(got_p[DLY+FRAME] || got_n[DLY+FRAME] || got_p[DLY+FRAME-4]
              || got_n[DLY+FRAME-4], "R9", "run across framing bit substituted", 0, 1);
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_transparent();
        t_jam();
        t_b8zs();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule